// File: doc/BRIEF.md
# Motor Stall Protection Timer

This block guards a brushless motor drive against a stalled rotor. While the drive is commanded to run and the speed loop reports that it has not reached its lock window, a timer advances. If that unlocked condition lasts for a programmed number of prescaled ticks, the block latches a fault output that forces the low-side drivers off. A seconds-range timeout fits a 24-bit count because the timer advances only on ticks of a programmable clock divider.

The fault stays latched for as long as the run command persists, even if the lock flag comes back. It is cleared by a power-up reset or by a stop command that lasts long enough. A stop that is too short clears nothing. The timer keeps its partial count through such a stop, so the next trip after restart comes early. Clearing the enable input turns the protection off completely.

Top module: `stall_guard`

## Requirements
- R1: After reset the output `lowside_off` is 0, and the unlock timer and prescaler start from zero.
- R2: While `run_cmd`=1, `guard_en`=1, `speed_locked`=0 and no fault is latched, the unlock timer advances by one on every prescaler tick. With a timeout T ≥ 1 and divider value P, `lowside_off` rises at the clock edge that ends the T·(P+1)-th such cycle.
- R3: The prescaler produces one tick every P+1 counting cycles. It restarts from zero whenever counting is suspended, so a partial tick period is never carried over.
- R4: A cycle with `run_cmd`=1 and `speed_locked`=1 clears the unlock timer. A fresh unlocked stretch then needs the full timeout, and a locked motor never trips.
- R5: Once latched, `lowside_off` stays 1 for as long as `run_cmd`=1 and `guard_en`=1, whatever `speed_locked` does.
- R6: A stop (`run_cmd`=0) that lasts `rearm_cycles` clock cycles clears both the fault and the unlock timer at the edge that ends the `rearm_cycles`-th stop cycle. A value of 0 acts as 1.
- R7: A stop shorter than `rearm_cycles` clears neither the fault nor the timer. After such a stop, an unlocked run trips after only the remaining ticks.
- R8: While `guard_en`=0, the fault and the timer are held at zero and `lowside_off` is 0 from the next edge on. After re-enabling, a full timeout is needed.
- R9: A timeout value of 0 behaves as 1: the fault latches on the first prescaler tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-up reset) |
| run_cmd | input | 1 | 1 = start condition, 0 = stop condition |
| speed_locked | input | 1 | 1 = motor speed inside the lock window |
| guard_en | input | 1 | 1 = protection active, 0 = protection off |
| prescale_div | input | 16 | Divider value P; one tick every P+1 cycles |
| timeout_ticks | input | 24 | Unlocked ticks before the fault latches |
| rearm_cycles | input | 16 | Minimum stop length, in clock cycles, that clears the fault and timer |
| lowside_off | output | 1 | Latched protection: 1 turns the low-side drivers off |

## Verification
The assertions check on every cycle how the fault may move. It rises only after a cycle of enabled, unlocked running. It falls only after a stop or a disable. It holds through a continued run and never rises while the motor is locked. Ticks appear only while counting, and a re-arm happens only in an enabled stop. The exact trip instant for a given divider and timeout is something only the bench scenarios can show. The same holds for restarting the prescaler after a lock blip, for the early trip after a short stop, and for the cycle count a stop needs before it re-arms. The bench computes each of these from the requirement formulas.

// File: rtl/stall_guard_pkg.sv
`timescale 1ns/1ps
package stall_guard_pkg;

  localparam int unsigned TIMER_W_DEF = 24;
  localparam int unsigned DIV_W_DEF   = 16;
  localparam int unsigned STOP_W_DEF  = 16;

  // a prescaler tick is due when the phase counter has reached the divider value
  function automatic logic tick_due(input logic [31:0] phase, input logic [31:0] div);
    return phase >= div;
  endfunction

  // the fault is due when the incremented count reaches the limit (limit 0 acts as 1)
  function automatic logic trip_due(input logic [31:0] count, input logic [31:0] limit);
    logic [32:0] next_count;
    next_count = {1'b0, count} + 33'd1;
    return next_count >= {1'b0, limit};
  endfunction

  // re-arm is due when the stop, including this cycle, has lasted the minimum length
  function automatic logic rearm_due(input logic [31:0] stopped, input logic [31:0] min_len);
    logic [32:0] next_len;
    next_len = {1'b0, stopped} + 33'd1;
    return next_len >= {1'b0, min_len};
  endfunction

endpackage

// File: rtl/stall_prescaler.sv
`timescale 1ns/1ps
module stall_prescaler #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick
);
  import stall_guard_pkg::*;

  logic [DIV_W-1:0] phase_q;

  assign tick = active && tick_due(32'(phase_q), 32'(div_val));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (!active || tick) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end
endmodule

// File: rtl/stall_unlock_timer.sv
`timescale 1ns/1ps
module stall_unlock_timer #(
  parameter int unsigned TIMER_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               tick,
  input  logic [TIMER_W-1:0] limit,
  output logic               trip
);
  import stall_guard_pkg::*;

  localparam logic [TIMER_W-1:0] CNT_MAX = '1;

  logic [TIMER_W-1:0] count_q;

  assign trip = tick && trip_due(32'(count_q), 32'(limit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (clear) begin
      count_q <= '0;
    end else if (tick && (count_q != CNT_MAX)) begin
      count_q <= count_q + 1'b1;
    end
  end
endmodule

// File: rtl/stall_rearm_timer.sv
`timescale 1ns/1ps
module stall_rearm_timer #(
  parameter int unsigned STOP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stopping,
  input  logic [STOP_W-1:0] min_len,
  output logic              rearm
);
  import stall_guard_pkg::*;

  localparam logic [STOP_W-1:0] STOP_MAX = '1;

  logic [STOP_W-1:0] stopped_q;

  assign rearm = stopping && rearm_due(32'(stopped_q), 32'(min_len));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stopped_q <= '0;
    end else if (!stopping) begin
      stopped_q <= '0;
    end else if (stopped_q != STOP_MAX) begin
      stopped_q <= stopped_q + 1'b1;
    end
  end
endmodule

// File: rtl/stall_guard.sv
`timescale 1ns/1ps
module stall_guard #(
  parameter int unsigned TIMER_W = stall_guard_pkg::TIMER_W_DEF,
  parameter int unsigned DIV_W   = stall_guard_pkg::DIV_W_DEF,
  parameter int unsigned STOP_W  = stall_guard_pkg::STOP_W_DEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_cmd,
  input  logic               speed_locked,
  input  logic               guard_en,
  input  logic [DIV_W-1:0]   prescale_div,
  input  logic [TIMER_W-1:0] timeout_ticks,
  input  logic [STOP_W-1:0]  rearm_cycles,
  output logic               lowside_off
);

  // named internal events, visible to the bound checker
  logic fault_q;
  logic counting;
  logic stopping;
  logic tick;
  logic trip;
  logic rearm;
  logic timer_clear;

  assign counting    = run_cmd && guard_en && !speed_locked && !fault_q;
  assign stopping    = !run_cmd && guard_en;
  assign timer_clear = !guard_en || rearm || (run_cmd && speed_locked);

  stall_prescaler #(.DIV_W(DIV_W)) u_prescaler (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (counting),
    .div_val (prescale_div),
    .tick    (tick)
  );

  stall_unlock_timer #(.TIMER_W(TIMER_W)) u_unlock_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (timer_clear),
    .tick  (tick),
    .limit (timeout_ticks),
    .trip  (trip)
  );

  stall_rearm_timer #(.STOP_W(STOP_W)) u_rearm_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .stopping (stopping),
    .min_len  (rearm_cycles),
    .rearm    (rearm)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
    end else if (!guard_en || rearm) begin
      fault_q <= 1'b0;
    end else if (trip) begin
      fault_q <= 1'b1;
    end
  end

  assign lowside_off = fault_q;

endmodule

// File: rtl/stall_guard_sva.sv
`timescale 1ns/1ps
module stall_guard_sva (
  input logic clk,
  input logic rst_n,
  input logic run_cmd,
  input logic speed_locked,
  input logic guard_en,
  input logic lowside_off,
  input logic counting,
  input logic tick,
  input logic trip,
  input logic rearm
);

  assert_rise_needs_unlock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lowside_off) |-> $past(run_cmd && guard_en && !speed_locked));

  assert_tick_only_counting_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> counting);

  assert_trip_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    trip |-> tick);

  assert_locked_no_trip_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_cmd && guard_en && speed_locked && !lowside_off) |=> !lowside_off);

  assert_hold_in_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lowside_off && run_cmd && guard_en) |=> lowside_off);

  assert_fall_needs_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lowside_off) |-> $past(!run_cmd || !guard_en));

  assert_rearm_in_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rearm |-> (!run_cmd && guard_en));

  assert_disable_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !guard_en |=> !lowside_off);

endmodule

bind stall_guard stall_guard_sva u_sva (
  .clk          (clk),
  .rst_n        (rst_n),
  .run_cmd      (run_cmd),
  .speed_locked (speed_locked),
  .guard_en     (guard_en),
  .lowside_off  (lowside_off),
  .counting     (counting),
  .tick         (tick),
  .trip         (trip),
  .rearm        (rearm)
);

// File: tb/stall_guard_bench.sv
`timescale 1ns/1ps
module stall_guard_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_cmd = 1'b0;
  logic        speed_locked = 1'b1;
  logic        guard_en = 1'b1;
  logic [15:0] prescale_div = '0;
  logic [23:0] timeout_ticks = 24'd10;
  logic [15:0] rearm_cycles = 16'd4;
  logic        lowside_off;

  int tests_run = 0;
  int tests_failed = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  stall_guard u_stall_guard (
    .clk           (clk),
    .rst_n         (rst_n),
    .run_cmd       (run_cmd),
    .speed_locked  (speed_locked),
    .guard_en      (guard_en),
    .prescale_div  (prescale_div),
    .timeout_ticks (timeout_ticks),
    .rearm_cycles  (rearm_cycles),
    .lowside_off   (lowside_off)
  );

  // cycles of unlocked running until the fault, from the requirement formula
  function automatic int trip_cycles(input int t, input int p);
    int eff;
    eff = (t == 0) ? 1 : t;
    return eff * (p + 1);
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic exp, input string req, input string what);
    tests_run++;
    if (lowside_off !== exp) begin
      tests_failed++;
      $display("FAIL %s %s: lowside_off=%b expected %b", req, what, lowside_off, exp);
    end
  endtask

  task automatic long_stop();
    run_cmd = 1'b0;
    step(int'(rearm_cycles) + 1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(1);
    check(1'b0, "R1", "after reset");
  endtask

  task automatic t_basic_trip();
    int n;
    timeout_ticks = 24'd5; prescale_div = 16'd3;
    n = trip_cycles(5, 3);
    speed_locked = 1'b0; run_cmd = 1'b1;
    step(n - 1);
    check(1'b0, "R2", "one cycle before trip");
    step(1);
    check(1'b1, "R2", "at trip");
    rearm_cycles = 16'd4;
    speed_locked = 1'b1;
    run_cmd = 1'b0;
    step(3);
    check(1'b1, "R6", "stop one cycle short");
    step(1);
    check(1'b0, "R6", "stop reached minimum");
  endtask

  task automatic t_lock_clears();
    timeout_ticks = 24'd6; prescale_div = 16'd0;
    run_cmd = 1'b1; speed_locked = 1'b0;
    step(4);
    speed_locked = 1'b1;
    step(1);
    speed_locked = 1'b0;
    step(5);
    check(1'b0, "R4", "lock blip restarted timer");
    step(1);
    check(1'b1, "R4", "full timeout after lock blip");
    speed_locked = 1'b1;
    step(10);
    check(1'b1, "R5", "fault held while locked and running");
    long_stop();
    check(1'b0, "R6", "cleared by long stop");
  endtask

  task automatic t_prescale_restart();
    timeout_ticks = 24'd2; prescale_div = 16'd2;
    run_cmd = 1'b1; speed_locked = 1'b0;
    step(2);
    speed_locked = 1'b1;
    step(1);
    speed_locked = 1'b0;
    step(trip_cycles(2, 2) - 1);
    check(1'b0, "R3", "partial tick period discarded");
    step(1);
    check(1'b1, "R3", "trip after full prescaled timeout");
    long_stop();
  endtask

  task automatic t_short_stop();
    rearm_cycles = 16'd8; timeout_ticks = 24'd10; prescale_div = 16'd0;
    run_cmd = 1'b1; speed_locked = 1'b0;
    step(6);
    run_cmd = 1'b0;
    step(3);
    run_cmd = 1'b1;
    step(3);
    check(1'b0, "R7", "remaining count not yet used up");
    step(1);
    check(1'b1, "R7", "early trip after short stop");
    run_cmd = 1'b0;
    step(3);
    run_cmd = 1'b1;
    step(1);
    check(1'b1, "R7", "short stop left fault latched");
    run_cmd = 1'b0;
    step(7);
    check(1'b1, "R6", "stop of 7 of 8 cycles");
    step(1);
    check(1'b0, "R6", "stop of 8 cycles clears");
  endtask

  task automatic t_disable();
    timeout_ticks = 24'd1; prescale_div = 16'd0;
    guard_en = 1'b0; run_cmd = 1'b1; speed_locked = 1'b0;
    step(20);
    check(1'b0, "R8", "disabled never trips");
    timeout_ticks = 24'd3;
    guard_en = 1'b1;
    step(3);
    check(1'b1, "R8", "trips once enabled");
    guard_en = 1'b0;
    step(1);
    check(1'b0, "R8", "disable clears fault");
    guard_en = 1'b1;
    step(2);
    check(1'b0, "R8", "timer cleared by disable");
    step(1);
    check(1'b1, "R8", "full timeout after re-enable");
    long_stop();
  endtask

  task automatic t_zero_timeout();
    timeout_ticks = 24'd0; prescale_div = 16'd1;
    run_cmd = 1'b1; speed_locked = 1'b0;
    step(trip_cycles(0, 1) - 1);
    check(1'b0, "R9", "before first tick");
    step(1);
    check(1'b1, "R9", "zero timeout trips on first tick");
    long_stop();
    check(1'b0, "R9", "cleared after zero-timeout trip");
  endtask

  initial begin
    step(1);
    t_reset();
    t_basic_trip();
    t_lock_clears();
    t_prescale_restart();
    t_short_stop();
    t_disable();
    t_zero_timeout();
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (20000) @(posedge clk);
        tests_run++;
        tests_failed++;
        $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

endmodule